// File: doc/BRIEF.md
# Enhanced-Mode Register Bank for a Dual-Mode Floppy Controller

This block is the register set a floppy controller presents once it has been switched out of its legacy latch-based interface into its enhanced mode. A host reaches it over a narrow synchronous bus: the register number sits in the address bits above a fixed shift, and the eight low numbers are write-only registers while the eight high numbers are read-only registers. The bank keeps a drive phase byte, a mode byte that software can only change by clearing or setting selected bits, and a small parameter memory walked by one pointer shared by reads and writes.

Reads of the phase, parameter, status and handshake registers return live state; the handshake register answers the drive-present sense query. When software clears the mode-status bit through the clear port, the bank raises a one-cycle exit request so the front end can hand control back to the legacy interface and wipe its latches. Serial data, mark and CRC paths are not part of this block; their registers read as zero.

Top module: `fdc_enh_bank`

## Requirements
- R1: While `rst_ni` is low and after it rises, `rdata_o`, `mode_o` and `exit_o` are zero, the phase register and all parameter entries read 0x00, and the parameter pointer is 0.
- R2: The register number is `addr_i[REG_SHIFT+3:REG_SHIFT]` (REG_SHIFT = 9); address bits below the shift have no effect. Numbers 0 to 7 act only on writes, 8 to 15 only on reads.
- R3: A write to number 6 makes the mode byte equal to its old value AND NOT the written byte.
- R4: A write to number 7 makes the mode byte equal to its old value OR the written byte.
- R5: The parameter memory holds 16 bytes; a write to number 3 stores at the pointer and a read of number 11 returns the entry at the pointer, and each then advances the pointer by one, wrapping from 15 to 0.
- R6: Any write to number 6 returns the parameter pointer to 0, whatever the written byte.
- R7: A byte written to number 4 reads back unchanged from number 12.
- R8: A read of number 15 returns 0x08 when the phase register holds 0x77, and 0x00 otherwise.
- R9: A read of number 14 returns a byte whose bit 6 equals bit 6 of the mode byte and whose other bits are zero.
- R10: `exit_o` is high for exactly the cycle after a write to number 6 that leaves bit 6 of the mode byte at zero, and is low otherwise.
- R11: Reads of numbers 8, 9, 10 and 13 return 0x00; writes to numbers 0, 1, 2 and 5 change neither the mode byte, the phase register, the parameter memory nor the pointer.
- R12: While `active_i` is low, reads and writes change no state, `rdata_o` stays 0x00 and `exit_o` stays low.
- R13: Read data appears on `rdata_o` in the cycle after the read cycle and is 0x00 in any cycle not preceded by an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | High while this bank is the selected register set |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe, one access per cycle |
| addr_i | input | 13 | Bus address; register number in bits 12:9 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| mode_o | output | 8 | Current mode byte |
| exit_o | output | 1 | One-cycle request to return to legacy mode |

## Verification
Every cycle the checker confirms that the clear and set ports move only the masked mode bits, that the mode byte is otherwise steady, that the exit pulse has a clear-port write behind it and a zero mode-status bit in front of it, and that status, handshake and idle read data follow the registered read rule. Parameter memory order, pointer wrap past sixteen entries, the pointer clear on a clear-port write and the silence of the unused registers depend on the history of many accesses, so only the bench's directed sequences and its modelled random traffic show them.

// File: rtl/fdc_enh_pkg.sv
package fdc_enh_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    W_DAT  = 4'd0,  W_MRK  = 4'd1,  W_CRC = 4'd2,  W_PRM = 4'd3,
    W_PHS  = 4'd4,  W_SET  = 4'd5,  W_MCLR = 4'd6, W_MSET = 4'd7,
    R_DAT  = 4'd8,  R_MRK  = 4'd9,  R_ERR = 4'd10, R_PRM = 4'd11,
    R_PHS  = 4'd12, R_SET  = 4'd13, R_STS = 4'd14, R_HSK = 4'd15
  } reg_idx_e;

  typedef struct packed {
    logic prm_wr;
    logic phs_wr;
    logic mclr;
    logic mset;
    logic prm_rd;
    logic phs_rd;
    logic sts_rd;
    logic hsk_rd;
    logic rd_any;
  } acc_t;
endpackage

// File: rtl/fdc_enh_decode.sv
module fdc_enh_decode
  import fdc_enh_pkg::*;
(
  input  logic     active_i,
  input  logic     wr_en_i,
  input  logic     rd_en_i,
  input  reg_idx_e idx_i,
  output acc_t     acc_o
);
  logic wr_ok, rd_ok;

  // top bit of the number splits write and read halves
  assign wr_ok = active_i & wr_en_i & ~idx_i[IDX_W-1];
  assign rd_ok = active_i & rd_en_i &  idx_i[IDX_W-1];

  always_comb begin
    acc_o        = '0;
    acc_o.prm_wr = wr_ok && (idx_i == W_PRM);
    acc_o.phs_wr = wr_ok && (idx_i == W_PHS);
    acc_o.mclr   = wr_ok && (idx_i == W_MCLR);
    acc_o.mset   = wr_ok && (idx_i == W_MSET);
    acc_o.prm_rd = rd_ok && (idx_i == R_PRM);
    acc_o.phs_rd = rd_ok && (idx_i == R_PHS);
    acc_o.sts_rd = rd_ok && (idx_i == R_STS);
    acc_o.hsk_rd = rd_ok && (idx_i == R_HSK);
    acc_o.rd_any = rd_ok;
  end
endmodule

// File: rtl/fdc_enh_pram.sv
module fdc_enh_pram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          clr_ptr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[e] <= '0;
      else if (wr_i && ptr_q == PTR_W'(e))    mem_q[e] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ptr_q <= '0;
    else if (clr_ptr_i)    ptr_q <= '0;
    else if (wr_i || rd_i) ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  assign rdata_o = mem_q[ptr_q];
endmodule

// File: rtl/fdc_enh_ctl.sv
module fdc_enh_ctl #(
  parameter int unsigned DW       = 8,
  parameter int unsigned MODE_BIT = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phs_wr_i,
  input  logic          mclr_i,
  input  logic          mset_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] phase_o,
  output logic [DW-1:0] mode_o,
  output logic          exit_o
);
  logic [DW-1:0] phase_q, mode_q, mode_nx;
  logic          exit_q;

  always_comb begin
    mode_nx = mode_q;
    if (mclr_i)      mode_nx = mode_q & ~wdata_i;
    else if (mset_i) mode_nx = mode_q | wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      mode_q  <= '0;
      exit_q  <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      if (phs_wr_i) phase_q <= wdata_i;
      // status bit gone after a clear-port write: hand back to legacy set
      exit_q <= mclr_i & ~mode_nx[MODE_BIT];
    end
  end

  assign phase_o = phase_q;
  assign mode_o  = mode_q;
  assign exit_o  = exit_q;
endmodule

// File: rtl/fdc_enh_bank.sv
module fdc_enh_bank
  import fdc_enh_pkg::*;
#(
  parameter int unsigned REG_SHIFT   = 9,
  parameter int unsigned DW          = 8,
  parameter int unsigned PRAM_DEPTH  = 16,
  parameter int unsigned MODE_BIT    = 6,
  parameter logic [7:0]  SENSE_QUERY = 8'h77,
  parameter logic [7:0]  SENSE_VAL   = 8'h08,
  localparam int unsigned ADDR_W     = REG_SHIFT + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     mode_o,
  output logic              exit_o
);
  reg_idx_e      idx;
  acc_t          acc;
  logic [DW-1:0] prm_rdata, phase_q, rd_val, rdata_q;
  logic          unused_addr;

  assign idx         = reg_idx_e'(addr_i[REG_SHIFT +: IDX_W]);
  assign unused_addr = ^addr_i[REG_SHIFT-1:0];

  fdc_enh_decode u_dec (
    .active_i (active_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .idx_i    (idx),
    .acc_o    (acc)
  );

  fdc_enh_pram #(.DEPTH(PRAM_DEPTH), .DW(DW)) u_pram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (acc.prm_wr),
    .rd_i      (acc.prm_rd),
    .clr_ptr_i (acc.mclr),
    .wdata_i   (wdata_i),
    .rdata_o   (prm_rdata)
  );

  fdc_enh_ctl #(.DW(DW), .MODE_BIT(MODE_BIT)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phs_wr_i (acc.phs_wr),
    .mclr_i   (acc.mclr),
    .mset_i   (acc.mset),
    .wdata_i  (wdata_i),
    .phase_o  (phase_q),
    .mode_o   (mode_o),
    .exit_o   (exit_o)
  );

  always_comb begin
    rd_val = '0;
    if (acc.prm_rd) rd_val = prm_rdata;
    if (acc.phs_rd) rd_val = phase_q;
    if (acc.sts_rd) rd_val[MODE_BIT] = mode_o[MODE_BIT];
    if (acc.hsk_rd) rd_val = (phase_q == DW'(SENSE_QUERY)) ? DW'(SENSE_VAL) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= acc.rd_any ? rd_val : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fdc_enh_bank_chk.sv
module fdc_enh_bank_chk #(
  parameter int unsigned REG_SHIFT   = 9,
  parameter int unsigned DW          = 8,
  parameter int unsigned MODE_BIT    = 6,
  parameter logic [7:0]  SENSE_QUERY = 8'h77,
  parameter logic [7:0]  SENSE_VAL   = 8'h08,
  localparam int unsigned ADDR_W     = REG_SHIFT + 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [DW-1:0]     mode_o,
  input logic              exit_o,
  input logic [DW-1:0]     phase_i
);
  logic [3:0] n;
  logic       wr_ok, rd_ok;
  assign n     = addr_i[REG_SHIFT +: 4];
  assign wr_ok = active_i && wr_en_i && !n[3];
  assign rd_ok = active_i && rd_en_i && n[3];

  // R3
  mode_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && n == 4'd6) |=> ((mode_o & $past(wdata_i)) == '0));

  // R4
  mode_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && n == 4'd7) |=> ((mode_o & $past(wdata_i)) == $past(wdata_i)));

  // R12
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ok && (n == 4'd6 || n == 4'd7)) |=> $stable(mode_o));

  // R10
  exit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> ($past(wr_ok && n == 4'd6) && !mode_o[MODE_BIT]));

  // R13
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok |=> (rdata_o == '0));

  // R8
  hsk_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && n == 4'd15) |=>
      (rdata_o == (($past(phase_i) == DW'(SENSE_QUERY)) ? DW'(SENSE_VAL) : '0)));

  // R9
  sts_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && n == 4'd14) |=>
      (rdata_o == (DW'($past(mode_o[MODE_BIT])) << MODE_BIT)));
endmodule

bind fdc_enh_bank fdc_enh_bank_chk #(
  .REG_SHIFT(REG_SHIFT), .DW(DW), .MODE_BIT(MODE_BIT),
  .SENSE_QUERY(SENSE_QUERY), .SENSE_VAL(SENSE_VAL)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .active_i (active_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .mode_o   (mode_o),
  .exit_o   (exit_o),
  .phase_i  (phase_q)
);

// File: tb/sim_fdc_enh_bank.sv
module sim_fdc_enh_bank;
  localparam int RS = 9;
  localparam int AW = RS + 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          active_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o, mode_o;
  logic          exit_o;

  int n_chk = 0, n_fail = 0;

  logic [7:0] m_mode, m_phase;
  logic [7:0] m_pram [16];
  int         m_ptr;

  always #2 clk_i = ~clk_i;

  fdc_enh_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .mode_o(mode_o), .exit_o(exit_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = '0; m_phase = '0; m_ptr = 0;
    for (int i = 0; i < 16; i++) m_pram[i] = '0;
  endtask

  task automatic do_op(input bit act, input bit wr, input bit rd,
                       input logic [3:0] idx, input logic [7:0] d, input string req);
    logic [7:0] e_rd = '0;
    bit e_exit = 1'b0;
    if (act && rd && idx[3]) begin
      case (idx)
        4'd11: begin e_rd = m_pram[m_ptr]; m_ptr = (m_ptr + 1) % 16; end
        4'd12: e_rd = m_phase;
        4'd14: e_rd = {1'b0, m_mode[6], 6'b0};
        4'd15: e_rd = (m_phase == 8'h77) ? 8'h08 : 8'h00;
        default: e_rd = '0;
      endcase
    end
    if (act && wr && !idx[3]) begin
      case (idx)
        4'd3: begin m_pram[m_ptr] = d; m_ptr = (m_ptr + 1) % 16; end
        4'd4: m_phase = d;
        4'd6: begin m_mode = m_mode & ~d; m_ptr = 0; e_exit = !m_mode[6]; end
        4'd7: m_mode = m_mode | d;
        default: ;
      endcase
    end
    @(negedge clk_i);
    active_i = act; wr_en_i = wr; rd_en_i = rd; wdata_i = d;
    addr_i = {idx, RS'($urandom)};
    @(posedge clk_i); #1;
    chk8({req, " rdata"}, rdata_o, e_rd);
    chk8({req, " exit"}, {7'b0, exit_o}, {7'b0, e_exit});
    chk8({req, " mode"}, mode_o, m_mode);
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; active_i = 0; wr_en_i = 0; rd_en_i = 0;
    model_reset();
    repeat (2) @(posedge clk_i);
    #1;
    // R1 outputs during reset
    chk8("R1 rdata", rdata_o, 8'h00);
    chk8("R1 mode", mode_o, 8'h00);
    chk8("R1 exit", {7'b0, exit_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    apply_reset();
    // R1 state after reset
    do_op(1, 0, 1, 4'd12, 8'h00, "R1 phase");
    do_op(1, 0, 1, 4'd11, 8'h00, "R1 pram");
    do_op(1, 0, 1, 4'd14, 8'h00, "R1 status");
    do_op(0, 0, 0, 4'd0, 8'h00, "R13 idle");
    // R7 phase round trip
    do_op(1, 1, 0, 4'd4, 8'h5a, "R7 wr");
    do_op(1, 0, 1, 4'd12, 8'h00, "R7 rd");
    do_op(1, 1, 0, 4'd4, 8'ha5, "R7 wr2");
    do_op(1, 0, 1, 4'd12, 8'h00, "R7 rd2");
    // R8 sense query
    do_op(1, 1, 0, 4'd4, 8'h77, "R8 wr");
    do_op(1, 0, 1, 4'd15, 8'h00, "R8 present");
    do_op(1, 1, 0, 4'd4, 8'h76, "R8 wr2");
    do_op(1, 0, 1, 4'd15, 8'h00, "R8 absent");
    // R4 set port, R9 status
    do_op(1, 1, 0, 4'd7, 8'h40, "R4 set");
    do_op(1, 1, 0, 4'd7, 8'h81, "R4 set2");
    do_op(1, 0, 1, 4'd14, 8'h00, "R9 status on");
    // R3 clear port keeping bit 6, no exit
    do_op(1, 1, 0, 4'd6, 8'h01, "R3 clr");
    // R5 pointer wraps over 17 writes
    for (int i = 0; i < 17; i++) do_op(1, 1, 0, 4'd3, 8'(8'h10 + i), "R5 wr");
    do_op(1, 0, 1, 4'd11, 8'h00, "R5 rd after wrap");
    // R6 clear port with zero mask resets pointer only
    do_op(1, 1, 0, 4'd6, 8'h00, "R6 clr");
    for (int i = 0; i < 16; i++) do_op(1, 0, 1, 4'd11, 8'h00, "R5 rd");
    // R11 unused writes and reads
    do_op(1, 1, 0, 4'd0, 8'hff, "R11 w0");
    do_op(1, 1, 0, 4'd1, 8'hff, "R11 w1");
    do_op(1, 1, 0, 4'd2, 8'hff, "R11 w2");
    do_op(1, 1, 0, 4'd5, 8'hff, "R11 w5");
    do_op(1, 0, 1, 4'd12, 8'h00, "R11 phase kept");
    do_op(1, 0, 1, 4'd11, 8'h00, "R11 ptr kept");
    foreach (m_pram[i]) if (i == 0) begin end
    do_op(1, 0, 1, 4'd8, 8'h00, "R11 r8");
    do_op(1, 0, 1, 4'd9, 8'h00, "R11 r9");
    do_op(1, 0, 1, 4'd10, 8'h00, "R11 r10");
    do_op(1, 0, 1, 4'd13, 8'h00, "R11 r13");
    // R2 write-half number with read strobe does nothing
    do_op(1, 0, 1, 4'd4, 8'h00, "R2 rd low half");
    do_op(1, 1, 0, 4'd12, 8'h33, "R2 wr high half");
    // R12 inactive accesses
    do_op(0, 1, 0, 4'd7, 8'hff, "R12 set");
    do_op(0, 0, 1, 4'd12, 8'h00, "R12 rd");
    do_op(0, 1, 0, 4'd6, 8'hff, "R12 clr");
    // R10 exit pulse
    do_op(1, 1, 0, 4'd6, 8'h40, "R10 exit");
    do_op(0, 0, 0, 4'd0, 8'h00, "R10 one cycle");
    do_op(1, 1, 0, 4'd6, 8'h00, "R10 already clear");
    do_op(0, 0, 0, 4'd0, 8'h00, "R13 idle2");
    // R2 random traffic with random low address bits
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] ix = 4'($urandom);
      bit a = ($urandom % 8) != 0;
      bit w = !ix[3] ? ($urandom % 4 != 0) : ($urandom % 8 == 0);
      bit r = ix[3]  ? ($urandom % 4 != 0) : ($urandom % 8 == 0);
      logic [7:0] d = ($urandom % 4 == 0) ? 8'h77 : 8'($urandom);
      do_op(a, w, r, ix, d, "R2 rand");
    end
    // R1 reset clears memory again
    apply_reset();
    do_op(1, 0, 1, 4'd11, 8'h00, "R1 pram cleared");
    do_op(1, 0, 1, 4'd12, 8'h00, "R1 phase cleared");
    summary();
  end
endmodule